// File: doc/BRIEF.md
# Multi-port cell transmit slave

This block is the transmit-side slave of a 16-bit multi-PHY cell bus. Three ports sit behind one shared bus, and each port has its own 5-bit bus address, supplied as a configuration input. An upstream master polls a port by driving that port's address. One cycle later the block answers with a cell-space indication. The indication is driven only when the address belongs to one of the ports; otherwise its output enable is low.

To transfer a cell, the master drives the port's address, then raises the enable and sends 27 words, marking the first word with start-of-cell. Each port keeps its words in a buffer that holds three whole cells. On the output side, complete cells are offered to a downstream consumer one word per pop.

Every enabled word has its odd parity checked. A mismatch only sets a sticky per-port flag, and only while parity checking is switched on. A cell that starts when its port has no free slot is discarded whole, and a sticky per-port overflow flag is set.

Top module: `cell_tx_mphy`

## Requirements
- R1: After reset, `cell_space_oe_o`, `cell_space_o`, every `cell_rdy_o`, `par_err_o` and `ovf_o` bit are 0.
- R2: On the clock edge after `tx_addr_i` equals the address of a port, `cell_space_oe_o` is 1. When no port matches, `cell_space_oe_o` and `cell_space_o` are both 0. If two ports share an address, the lower-indexed port answers.
- R3: When enabled, `cell_space_o` is 1 exactly when the polled port has fewer than 3 occupied slots. A slot is occupied by a stored complete cell or by a cell currently being written. The status is taken in the cycle the address was present.
- R4: A transfer goes to the port whose address was on `tx_addr_i` in the last cycle with `tx_en_i` low. Addresses driven while `tx_en_i` stays high are polls only and do not redirect data.
- R5: A cell is 27 words. The first word carries `tx_soc_i`. The cell becomes poppable (`cell_rdy_o` high) on the edge that stores its 27th word.
- R6: A `tx_soc_i` word that arrives while a cell is part-written restarts that cell in the same slot. The earlier partial words are discarded.
- R7: Enabled words without `tx_soc_i` that are not part of a cell being written are ignored.
- R8: A start-of-cell arriving when the port has 3 occupied slots drops that whole cell and sets the port's `ovf_o` bit, which stays set until reset. Stored cells are unaffected.
- R9: With `par_chk_en_i` high, an enabled word whose 16 data bits plus `tx_par_i` have an even number of ones sets the selected port's `par_err_o` bit (sticky). With `par_chk_en_i` low no bit is set. In both cases the word is stored normally.
- R10: While `cell_rdy_o[p]` is high, `pop_data_o[p]` shows the oldest unread word and `pop_sof_o[p]` marks the first word of a cell. A high `pop_i[p]` advances by one word, and popping the 27th word frees the slot. `pop_i` has no effect while `cell_rdy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running bus clock from the master |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_addr_i | input | 5 | Poll and select address |
| tx_en_i | input | 1 | High on cycles carrying a data word |
| tx_soc_i | input | 1 | Marks the first word of a cell |
| tx_data_i | input | 16 | Data word |
| tx_par_i | input | 1 | Odd parity bit for tx_data_i |
| port_addr_i | input | 15 | Port bus addresses, port p at bits [5p+4:5p] |
| par_chk_en_i | input | 1 | Enables parity error flagging |
| cell_space_o | output | 1 | Polled port has room for a full cell |
| cell_space_oe_o | output | 1 | Output enable for cell_space_o (tri-state control) |
| pop_i | input | 3 | Per-port word pop request |
| cell_rdy_o | output | 3 | Per-port: at least one complete cell stored |
| pop_data_o | output | 48 | Per-port head word, port p at bits [16p+15:16p] |
| pop_sof_o | output | 3 | Per-port: head word is the first of its cell |
| par_err_o | output | 3 | Sticky per-port parity error flags |
| ovf_o | output | 3 | Sticky per-port dropped-cell flags |

## Verification
The bench builds the block with its default values: three ports, 27-word cells and three slots per port. With these values a port fills after 81 words, so full-buffer polls and whole-cell drops are reached quickly. Draining the port afterwards wraps its read and write bases past the last slot. The bench configures distinct port addresses and then drives an unmatched address. Polls are interleaved with live transfers, which exercises the rule that the port is selected before the enable rises. Partial cells, stray words and single bad-parity words are injected on chosen ports, with checking both off and on.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;
  localparam int unsigned CELL_WORDS_DEF = 27;
  localparam int unsigned SLOTS_DEF      = 3;

  // odd parity: data plus parity bit carry an odd number of ones
  function automatic logic odd_ok(input logic [31:0] d, input logic p);
    return ^{d, p};
  endfunction
endpackage

// File: rtl/tx_port_match.sv
module tx_port_match #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] port_addr_i,
  output logic [NUM_PORTS-1:0]        hit_o,
  output logic                        any_o
);
  logic [NUM_PORTS-1:0] eq;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cmp
    assign eq[p] = (addr_i == port_addr_i[p*ADDR_W +: ADDR_W]);
  end

  // lowest index wins on duplicate addresses
  always_comb begin
    hit_o = '0;
    for (int p = NUM_PORTS-1; p >= 0; p--) begin
      if (eq[p]) hit_o = NUM_PORTS'(1) << p;
    end
  end

  assign any_o = |eq;
endmodule

// File: rtl/tx_cell_buffer.sv
module tx_cell_buffer
  import cell_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CELL_WORDS = CELL_WORDS_DEF,
  parameter int unsigned SLOTS      = SLOTS_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              soc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              par_en_i,
  input  logic              pop_i,
  output logic              room_o,
  output logic              cell_rdy_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_sof_o,
  output logic              par_err_o,
  output logic              ovf_o
);
  localparam int unsigned DEPTH = SLOTS * CELL_WORDS;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned WW    = $clog2(CELL_WORDS);
  localparam int unsigned CW    = $clog2(SLOTS + 1);
  localparam logic [AW-1:0] LAST_BASE = AW'((SLOTS - 1) * CELL_WORDS);
  localparam logic [AW-1:0] STEP      = AW'(CELL_WORDS);
  localparam logic [WW-1:0] LAST_WORD = WW'(CELL_WORDS - 1);
  localparam logic [CW:0]   SLOTS_C   = (CW+1)'(SLOTS);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_base_q, rd_base_q;
  logic [WW-1:0] wr_word_q, rd_word_q, idx;
  logic [CW-1:0] cells_q;
  logic          writing_q, perr_q, ovf_q;
  logic [CW:0]   used;
  logic          store, commit, pop_fire, rd_last;

  function automatic logic [AW-1:0] next_base(input logic [AW-1:0] b);
    return (b == LAST_BASE) ? '0 : b + STEP;
  endfunction

  assign used     = {1'b0, cells_q} + (CW+1)'(writing_q);
  assign room_o   = used < SLOTS_C;
  assign store    = wr_i & (soc_i ? (writing_q | room_o) : writing_q);
  assign idx      = soc_i ? '0 : wr_word_q;
  assign commit   = store & (idx == LAST_WORD);
  assign pop_fire = pop_i & (cells_q != '0);
  assign rd_last  = pop_fire & (rd_word_q == LAST_WORD);

  always_ff @(posedge clk_i) begin
    if (store) mem_q[wr_base_q + AW'(idx)] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_base_q <= '0;
      wr_word_q <= '0;
      writing_q <= 1'b0;
      rd_base_q <= '0;
      rd_word_q <= '0;
      cells_q   <= '0;
      perr_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (commit) begin
        writing_q <= 1'b0;
        wr_word_q <= '0;
        wr_base_q <= next_base(wr_base_q);
      end else if (store) begin
        writing_q <= 1'b1;
        wr_word_q <= idx + WW'(1);
      end
      if (rd_last) begin
        rd_word_q <= '0;
        rd_base_q <= next_base(rd_base_q);
      end else if (pop_fire) begin
        rd_word_q <= rd_word_q + WW'(1);
      end
      cells_q <= cells_q + CW'(commit) - CW'(rd_last);
      if (wr_i && soc_i && !writing_q && !room_o) ovf_q <= 1'b1;
      if (wr_i && par_en_i && !odd_ok(32'(data_i), par_i)) perr_q <= 1'b1;
    end
  end

  assign cell_rdy_o = cells_q != '0;
  assign pop_data_o = mem_q[rd_base_q + AW'(rd_word_q)];
  assign pop_sof_o  = cell_rdy_o & (rd_word_q == '0);
  assign par_err_o  = perr_q;
  assign ovf_o      = ovf_q;

  // R3
  slots_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= SLOTS_C);
  // R10
  pop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_rdy_o |=> $stable(rd_word_q) && $stable(rd_base_q));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  // R9
  perr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_en_i |=> $stable(perr_q));
endmodule

// File: rtl/cell_tx_mphy.sv
module cell_tx_mphy
  import cell_tx_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 3,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CELL_WORDS = CELL_WORDS_DEF,
  parameter int unsigned SLOTS      = SLOTS_DEF
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           tx_addr_i,
  input  logic                        tx_en_i,
  input  logic                        tx_soc_i,
  input  logic [DATA_W-1:0]           tx_data_i,
  input  logic                        tx_par_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] port_addr_i,
  input  logic                        par_chk_en_i,
  output logic                        cell_space_o,
  output logic                        cell_space_oe_o,
  input  logic [NUM_PORTS-1:0]        pop_i,
  output logic [NUM_PORTS-1:0]        cell_rdy_o,
  output logic [NUM_PORTS*DATA_W-1:0] pop_data_o,
  output logic [NUM_PORTS-1:0]        pop_sof_o,
  output logic [NUM_PORTS-1:0]        par_err_o,
  output logic [NUM_PORTS-1:0]        ovf_o
);
  logic [NUM_PORTS-1:0] hit, sel_q, room;
  logic                 any_hit, space_q, space_oe_q;

  tx_port_match #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_match (
    .addr_i      (tx_addr_i),
    .port_addr_i (port_addr_i),
    .hit_o       (hit),
    .any_o       (any_hit)
  );

  // select latches while the bus is idle, holds through the transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= '0;
      space_q    <= 1'b0;
      space_oe_q <= 1'b0;
    end else begin
      if (!tx_en_i) sel_q <= hit;
      space_oe_q <= any_hit;
      space_q    <= |(hit & room);
    end
  end

  assign cell_space_o    = space_q;
  assign cell_space_oe_o = space_oe_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    tx_cell_buffer #(
      .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .SLOTS(SLOTS)
    ) u_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (tx_en_i & sel_q[p]),
      .soc_i      (tx_soc_i),
      .data_i     (tx_data_i),
      .par_i      (tx_par_i),
      .par_en_i   (par_chk_en_i),
      .pop_i      (pop_i[p]),
      .room_o     (room[p]),
      .cell_rdy_o (cell_rdy_o[p]),
      .pop_data_o (pop_data_o[p*DATA_W +: DATA_W]),
      .pop_sof_o  (pop_sof_o[p]),
      .par_err_o  (par_err_o[p]),
      .ovf_o      (ovf_o[p])
    );
  end

  // R4
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_q));
  // R4
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |=> $stable(sel_q));
  // R2
  space_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_space_oe_o |-> !cell_space_o);
endmodule

// File: tb/cell_tx_mphy_tb.sv
module cell_tx_mphy_tb;
  localparam int NP = 3;
  localparam int CWD = 27;
  localparam int SL = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [4:0] tx_addr = '0;
  logic tx_en = 1'b0, tx_soc = 1'b0, tx_par = 1'b0, par_en = 1'b1;
  logic [15:0] tx_data = '0;
  logic [14:0] port_addr = {5'h1E, 5'h11, 5'h03};
  logic [NP-1:0] pop = '0;
  logic space, space_oe;
  logic [NP-1:0] rdy, sof, perr, ovf;
  logic [NP*16-1:0] pdata;

  int errors = 0, checks = 0;
  bit run = 0;

  always #4 clk = ~clk;

  cell_tx_mphy u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_addr_i(tx_addr), .tx_en_i(tx_en),
    .tx_soc_i(tx_soc), .tx_data_i(tx_data), .tx_par_i(tx_par),
    .port_addr_i(port_addr), .par_chk_en_i(par_en),
    .cell_space_o(space), .cell_space_oe_o(space_oe), .pop_i(pop),
    .cell_rdy_o(rdy), .pop_data_o(pdata), .pop_sof_o(sof),
    .par_err_o(perr), .ovf_o(ovf)
  );

  // reference model
  logic [15:0] mq [NP][$];
  logic [15:0] mpart [NP][$];
  int mc [NP], mrd [NP], oc [NP];
  bit mw [NP], ow [NP], mperr [NP], movf [NP];
  int msel = -1, mm;
  bit exp_oe = 0, exp_space = 0;

  function automatic int match(input logic [4:0] a);
    for (int p = 0; p < NP; p++) if (port_addr[p*5 +: 5] == a) return p;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (rst_ni && run) begin
    for (int p = 0; p < NP; p++) begin oc[p] = mc[p]; ow[p] = mw[p]; end
    mm = match(tx_addr);
    exp_oe = (mm >= 0);
    exp_space = (mm >= 0) && (oc[mm] + int'(ow[mm]) < SL);
    if (tx_en && msel >= 0) begin
      if (par_en && ((^tx_data) ^ tx_par) == 1'b0) mperr[msel] = 1;
      if (tx_soc) begin
        if (mw[msel] || (oc[msel] + int'(ow[msel]) < SL)) begin
          mw[msel] = 1; mpart[msel].delete(); mpart[msel].push_back(tx_data);
        end else movf[msel] = 1;
      end else if (mw[msel]) mpart[msel].push_back(tx_data);
      if (mw[msel] && mpart[msel].size() == CWD) begin
        foreach (mpart[msel][i]) mq[msel].push_back(mpart[msel][i]);
        mpart[msel].delete(); mc[msel]++; mw[msel] = 0;
      end
    end
    if (!tx_en) msel = mm;
    for (int p = 0; p < NP; p++) if (pop[p] && oc[p] > 0) begin
      void'(mq[p].pop_front());
      mrd[p]++;
      if (mrd[p] == CWD) begin mrd[p] = 0; mc[p]--; end
    end
  end

  always @(negedge clk) if (run) begin
    chk("R2 oe", space_oe, exp_oe);
    chk("R3 space", space, exp_space);
    for (int p = 0; p < NP; p++) begin
      chk($sformatf("R5 rdy p%0d", p), rdy[p], mc[p] > 0);
      chk($sformatf("R9 perr p%0d", p), perr[p], mperr[p]);
      chk($sformatf("R8 ovf p%0d", p), ovf[p], movf[p]);
      if (mc[p] > 0) begin
        chk($sformatf("R10 data p%0d", p), pdata[p*16 +: 16], mq[p][0]);
        chk($sformatf("R10 sof p%0d", p), sof[p], mrd[p] == 0);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); tx_en = 0; tx_soc = 0; end
  endtask

  task automatic poll(input logic [4:0] a);
    @(negedge clk); tx_en = 0; tx_soc = 0; tx_addr = a;
  endtask

  task automatic send(input logic [4:0] sel_a, input logic [4:0] poll_a,
                      input logic [15:0] base, input int n, input bit first_soc,
                      input int bad);
    @(negedge clk); tx_en = 0; tx_soc = 0; tx_addr = sel_a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_en = 1; tx_soc = first_soc && (i == 0); tx_addr = poll_a;
      tx_data = base + 16'(i);
      tx_par = ~(^tx_data) ^ (i == bad);
    end
    @(negedge clk); tx_en = 0; tx_soc = 0;
  endtask

  task automatic drain(input int p, input int n);
    @(negedge clk); pop[p] = 1;
    repeat (n) @(negedge clk);
    pop[p] = 0;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin mc[p] = 0; mrd[p] = 0; mw[p] = 0; mperr[p] = 0; movf[p] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 oe", space_oe, 0);
    chk("R1 space", space, 0);
    chk("R1 rdy", rdy, 0);
    chk("R1 perr", perr, 0);
    chk("R1 ovf", ovf, 0);
    rst_ni = 1;
    run = 1;
    // R2 polls, including unmatched address
    poll(5'h03); poll(5'h11); poll(5'h1E); poll(5'h07);
    idle(1);
    chk("R2 unmatched oe", space_oe, 0);
    // R4/R5 cell to port0 while polling port1
    send(5'h03, 5'h11, 16'h1000, CWD, 1, -1);
    chk("R4 port0 got cell", rdy, 3'b001);
    chk("R10 first word", pdata[15:0], 16'h1000);
    drain(0, CWD);
    idle(1);
    chk("R10 port0 empty", rdy[0], 0);
    // R8 fill port1, then overflow
    for (int c = 0; c < SL; c++) send(5'h11, 5'h11, 16'h2000 + 16'(c*64), CWD, 1, -1);
    poll(5'h11); idle(1);
    chk("R3 full space", space, 0);
    send(5'h11, 5'h03, 16'h2F00, CWD, 1, -1);
    chk("R8 ovf port1", ovf[1], 1);
    // R10 pop concurrent with new cell after space frees
    drain(1, CWD);
    send(5'h11, 5'h1E, 16'h2400, CWD, 1, -1);
    drain(1, 3 * CWD + 2);
    idle(1);
    chk("R8 port1 drained", rdy[1], 0);
    // R6 restart mid-cell on port2
    send(5'h1E, 5'h1E, 16'h3000, 10, 1, -1);
    send(5'h1E, 5'h1E, 16'h3100, 26, 1, -1);
    chk("R5 partial not ready", rdy[2], 0);
    send(5'h1E, 5'h1E, 16'h3200, CWD, 1, -1);
    chk("R6 restart first word", pdata[47:32], 16'h3200);
    drain(2, CWD + 3);
    // R7 stray words on port0
    send(5'h03, 5'h03, 16'h4000, 5, 0, -1);
    idle(1);
    chk("R7 stray ignored", rdy[0], 0);
    send(5'h03, 5'h03, 16'h4100, CWD, 1, -1);
    chk("R7 next cell head", pdata[15:0], 16'h4100);
    // R9 parity off then on
    par_en = 0;
    send(5'h03, 5'h03, 16'h5000, CWD, 1, 4);
    chk("R9 disabled no flag", perr[0], 0);
    par_en = 1;
    send(5'h1E, 5'h03, 16'h6000, CWD, 1, 9);
    chk("R9 flag port2", perr, 3'b100);
    drain(0, 2 * CWD);
    drain(2, CWD);
    idle(4);
    run = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule